// File: doc/BRIEF.md
# MDIO Management Register Controller

This block lets software run management transactions to external PHY or switch devices over a two-wire MDIO link. The processor sees six 32-bit registers on a small synchronous register bus. It programs the target device number and register number first. It then starts a transfer: writing a 16-bit value to the write-data register starts a write, and setting the read bit in the command register starts a read. Software polls a busy flag, and after a read it fetches the returned value from the result register.

Internally a programmable divider makes the MDC clock from the system clock, and a sequencer shifts out a complete management frame. Each frame carries a 32-bit preamble of ones, the start pattern, the opcode, both address fields, the turnaround and 16 data bits, most significant bit first. For reads the sequencer releases the data line for the turnaround and data bits, and captures the device's reply on rising MDC edges.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the indicator register (offset 0x34) reads 0, the configuration register (offset 0x20) reads divider code 7 in bits 3:0, and MDC and the output enable are low.
- R2: While a frame runs, MDC has a period of 2*(N+1) system clocks for divider code N. MDC stays low whenever no frame is running.
- R3: The divider code is written to bits 3:0 of the configuration register. A code below 2 is stored as 2 and a code above 9 is stored as 9, and the stored code reads back.
- R4: Writing the write-data register (offset 0x2c, bits 15:0) while idle sends 32 ones, 01, opcode 01, the 5-bit device number, the 5-bit register number, 10, then the 16 data bits MSB first. The output enable is high for all 64 bit times.
- R5: A read frame sends opcode 10 and holds the output enable low for the last 18 bit times. The 16 bits sampled on MDIO input appear, MSB first, in bits 15:0 of the result register (offset 0x30) when busy drops.
- R6: Indicator bit 0 (busy) is high from the clock edge that accepts a start until the frame ends. Indicator bit 2 (invalid) is high only while a read frame is in progress.
- R7: Writes to the address (0x28), command (0x24) or write-data (0x2c) registers while busy are ignored: the registers keep their values and no extra frame is sent.
- R8: A read starts only when a write changes command bit 0 from 0 to 1. Writing 1 again while the bit already holds 1 starts nothing.
- R9: Writing the configuration register with bit 31 set aborts any frame at once: busy and invalid clear, and MDC and the output enable go low. Bit 31 always reads back as 0, and the code bits in the same write are stored.
- R10: The address register holds the device number in bits 12:8 and the register number in bits 4:0. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational from bus_addr) |
| mdc_o | output | 1 | Management clock to the devices |
| mdio_o | output | 1 | Management data driven out |
| mdio_oe_o | output | 1 | Output enable for mdio_o |
| mdio_i | input | 1 | Management data sampled in |

## Verification
The assertions check on every cycle that MDC and the output enable stay low when no frame is running, and that invalid is never set without busy. They also check that an abort write leaves the link quiet on the next cycle, and that the address fields do not move while busy. Only the bench's scenarios can show the bit-exact frame contents, the MDC period for each divider code, the returned read value, and the 0-to-1 rule for starting a read. The bench also shows that writes made during a frame neither change registers nor start a second frame.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int MGMT_ADDR_W = 8;
    localparam int BUS_W       = 32;
    localparam int PHY_W       = 5;
    localparam int REGN_W      = 5;
    localparam int DATA_W      = 16;

    // Register offsets. The software sequence depends on these positions.
    localparam logic [MGMT_ADDR_W-1:0] OFS_CFG    = 8'h20;
    localparam logic [MGMT_ADDR_W-1:0] OFS_CMD    = 8'h24;
    localparam logic [MGMT_ADDR_W-1:0] OFS_ADDR   = 8'h28;
    localparam logic [MGMT_ADDR_W-1:0] OFS_WDATA  = 8'h2c;
    localparam logic [MGMT_ADDR_W-1:0] OFS_RESULT = 8'h30;
    localparam logic [MGMT_ADDR_W-1:0] OFS_IND    = 8'h34;

    localparam int CFG_ABORT_BIT = 31;
    localparam int CMD_READ_BIT  = 0;
    localparam int ADR_PHY_LSB   = 8;
    localparam int IND_BUSY_BIT  = 0;
    localparam int IND_INV_BIT   = 2;

    // Fields of one management transaction.
    typedef struct packed {
        logic [PHY_W-1:0]  phy;
        logic [REGN_W-1:0] regn;
        logic [DATA_W-1:0] data;
    } frame_req_t;

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [DIV_W-1:0] code,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } div_st_t;

    div_st_t st_q, st_d;
    logic    hit;

    always_comb begin
        st_d = st_q;
        hit  = run && (st_q.cnt >= code);
        if (clr || !run) begin
            st_d.cnt = '0;
            st_d.mdc = 1'b0;
        end else if (hit) begin
            st_d.cnt = '0;
            st_d.mdc = ~st_q.mdc;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mdc  = st_q.mdc;
    assign rise = hit && !st_q.mdc && !clr;
    assign fall = hit &&  st_q.mdc && !clr;

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_mgmt_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              start_wr,
    input  logic              start_rd,
    input  frame_req_t        req,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdi,
    output logic              busy,
    output logic              invalid,
    output logic              mdo,
    output logic              oe,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_data
);

    localparam int FRAME_BITS = PRE_LEN + 4 + PHY_W + REGN_W + 2 + DATA_W;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(FRAME_BITS - DATA_W - 2);
    localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(FRAME_BITS - DATA_W);

    typedef struct packed {
        logic                  busy;
        logic                  is_rd;
        logic [IDX_W-1:0]      idx;
        logic [FRAME_BITS-1:0] sh;
        logic [DATA_W-1:0]     cap;
    } seq_st_t;

    seq_st_t st_q, st_d;
    logic [FRAME_BITS-1:0] load_vec;
    logic                  done_d;

    always_comb begin
        load_vec = {{PRE_LEN{1'b1}}, 2'b01,
                    (start_rd ? 2'b10 : 2'b01),
                    req.phy, req.regn,
                    (start_rd ? 2'b00 : 2'b10),
                    (start_rd ? {DATA_W{1'b0}} : req.data)};
    end

    always_comb begin
        st_d   = st_q;
        done_d = 1'b0;
        if (abort) begin
            st_d.busy  = 1'b0;
            st_d.is_rd = 1'b0;
            st_d.idx   = '0;
        end else if (!st_q.busy) begin
            if (start_wr || start_rd) begin
                st_d.busy  = 1'b1;
                st_d.is_rd = start_rd;
                st_d.idx   = '0;
                st_d.sh    = load_vec;
            end
        end else begin
            if (rise && st_q.is_rd && (st_q.idx >= DATA_IDX)) begin
                st_d.cap = {st_q.cap[DATA_W-2:0], mdi};
            end
            if (fall) begin
                if (st_q.idx == LAST_IDX) begin
                    st_d.busy  = 1'b0;
                    st_d.is_rd = 1'b0;
                    st_d.idx   = '0;
                    done_d     = st_q.is_rd;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                    st_d.sh  = {st_q.sh[FRAME_BITS-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign invalid = st_q.busy && st_q.is_rd;
    assign mdo     = st_q.busy && st_q.sh[FRAME_BITS-1];
    assign oe      = st_q.busy && !(st_q.is_rd && (st_q.idx >= TA_IDX));
    assign rd_done = done_d;
    assign rd_data = st_q.cap;

endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV_W   = 4,
    parameter int DIV_MIN = 2,
    parameter int DIV_MAX = 9,
    parameter int DIV_RST = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [MGMT_ADDR_W-1:0] bus_addr,
    input  logic                   bus_we,
    input  logic [BUS_W-1:0]       bus_wdata,
    output logic [BUS_W-1:0]       bus_rdata,
    input  logic                   busy,
    input  logic                   invalid,
    input  logic                   rd_done,
    input  logic [DATA_W-1:0]      rd_data,
    output logic [DIV_W-1:0]       div_code,
    output logic                   abort,
    output logic                   start_wr,
    output logic                   start_rd,
    output frame_req_t             req
);

    typedef struct packed {
        logic [DIV_W-1:0]  code;
        logic              cmd;
        logic [PHY_W-1:0]  phy;
        logic [REGN_W-1:0] regn;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] result;
    } rb_st_t;

    rb_st_t st_q, st_d;
    logic   sel_cfg, sel_cmd, sel_addr, sel_wdata;
    logic   wdata_unused;

    function automatic logic [DIV_W-1:0] clamp_code(input logic [DIV_W-1:0] c);
        if (c < DIV_W'(DIV_MIN)) return DIV_W'(DIV_MIN);
        if (c > DIV_W'(DIV_MAX)) return DIV_W'(DIV_MAX);
        return c;
    endfunction

    assign wdata_unused = ^bus_wdata[CFG_ABORT_BIT-1:DATA_W];

    always_comb begin
        sel_cfg   = bus_we && (bus_addr == OFS_CFG);
        sel_cmd   = bus_we && (bus_addr == OFS_CMD);
        sel_addr  = bus_we && (bus_addr == OFS_ADDR);
        sel_wdata = bus_we && (bus_addr == OFS_WDATA);

        abort    = sel_cfg && bus_wdata[CFG_ABORT_BIT];
        start_rd = sel_cmd && !busy && bus_wdata[CMD_READ_BIT] && !st_q.cmd;
        start_wr = sel_wdata && !busy;

        st_d = st_q;
        if (sel_cfg) begin
            st_d.code = clamp_code(bus_wdata[DIV_W-1:0]);
        end
        if (sel_cmd && !busy) begin
            st_d.cmd = bus_wdata[CMD_READ_BIT];
        end
        if (sel_addr && !busy) begin
            st_d.phy  = bus_wdata[ADR_PHY_LSB +: PHY_W];
            st_d.regn = bus_wdata[REGN_W-1:0];
        end
        if (start_wr) begin
            st_d.wdata = bus_wdata[DATA_W-1:0];
        end
        if (rd_done) begin
            st_d.result = rd_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.code <= DIV_W'(DIV_RST);
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CFG:    bus_rdata[DIV_W-1:0] = st_q.code;
            OFS_CMD:    bus_rdata[CMD_READ_BIT] = st_q.cmd;
            OFS_ADDR: begin
                bus_rdata[ADR_PHY_LSB +: PHY_W] = st_q.phy;
                bus_rdata[REGN_W-1:0]           = st_q.regn;
            end
            OFS_WDATA:  bus_rdata[DATA_W-1:0] = st_q.wdata;
            OFS_RESULT: bus_rdata[DATA_W-1:0] = st_q.result;
            OFS_IND: begin
                bus_rdata[IND_BUSY_BIT] = busy;
                bus_rdata[IND_INV_BIT]  = invalid;
            end
            default:    bus_rdata = '0;
        endcase
    end

    assign div_code = st_q.code;
    assign req.phy  = st_q.phy;
    assign req.regn = st_q.regn;
    assign req.data = bus_wdata[DATA_W-1:0];

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV_W   = 4,
    parameter int DIV_MIN = 2,
    parameter int DIV_MAX = 9,
    parameter int DIV_RST = 7,
    parameter int PRE_LEN = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [MGMT_ADDR_W-1:0] bus_addr,
    input  logic                   bus_we,
    input  logic [BUS_W-1:0]       bus_wdata,
    output logic [BUS_W-1:0]       bus_rdata,
    output logic                   mdc_o,
    output logic                   mdio_o,
    output logic                   mdio_oe_o,
    input  logic                   mdio_i
);

    logic              seq_busy;
    logic              seq_invalid;
    logic              seq_done;
    logic [DATA_W-1:0] seq_rdata;
    logic [DIV_W-1:0]  div_code;
    logic              abort;
    logic              start_wr;
    logic              start_rd;
    logic              mdc_rise;
    logic              mdc_fall;
    frame_req_t        frm_req;

    mdio_reg_bank #(
        .DIV_W   (DIV_W),
        .DIV_MIN (DIV_MIN),
        .DIV_MAX (DIV_MAX),
        .DIV_RST (DIV_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (seq_busy),
        .invalid   (seq_invalid),
        .rd_done   (seq_done),
        .rd_data   (seq_rdata),
        .div_code  (div_code),
        .abort     (abort),
        .start_wr  (start_wr),
        .start_rd  (start_rd),
        .req       (frm_req)
    );

    mdio_clk_div #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (seq_busy),
        .clr   (abort),
        .code  (div_code),
        .mdc   (mdc_o),
        .rise  (mdc_rise),
        .fall  (mdc_fall)
    );

    mdio_frame_seq #(
        .PRE_LEN (PRE_LEN)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .abort    (abort),
        .start_wr (start_wr),
        .start_rd (start_rd),
        .req      (frm_req),
        .rise     (mdc_rise),
        .fall     (mdc_fall),
        .mdi      (mdio_i),
        .busy     (seq_busy),
        .invalid  (seq_invalid),
        .mdo      (mdio_o),
        .oe       (mdio_oe_o),
        .rd_done  (seq_done),
        .rd_data  (seq_rdata)
    );

endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk
    import mdio_mgmt_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic [MGMT_ADDR_W-1:0] bus_addr,
    input logic                   bus_we,
    input logic [BUS_W-1:0]       bus_wdata,
    input logic                   mdc,
    input logic                   oe,
    input logic                   busy,
    input logic                   invalid,
    input logic [PHY_W-1:0]       phy,
    input logic [REGN_W-1:0]      regn
);

    // R2: no clock on the link outside a frame
    a_r2_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    // R4: data line is never driven outside a frame
    a_r4_oe_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !oe);

    // R6: invalid flag only during a running frame
    a_r6_invalid_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        invalid |-> busy);

    // R9: abort quiets the link on the next cycle
    a_r9_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_addr == OFS_CFG) && bus_wdata[CFG_ABORT_BIT])
        |=> (!busy && !invalid && !mdc && !oe));

    // R7: address fields frozen against writes during a frame
    a_r7_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_we && (bus_addr == OFS_ADDR)) |=> ($stable(phy) && $stable(regn)));

endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .mdc       (mdc_o),
    .oe        (mdio_oe_o),
    .busy      (seq_busy),
    .invalid   (seq_invalid),
    .phy       (frm_req.phy),
    .regn      (frm_req.regn)
);

// File: tb/mdio_mgmt_ctrl_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_tb_top;

    localparam logic [7:0] A_CFG = 8'h20, A_CMD = 8'h24, A_ADR = 8'h28;
    localparam logic [7:0] A_WD  = 8'h2c, A_RES = 8'h30, A_IND = 8'h34;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc_o, mdio_o, mdio_oe_o;
    logic        mdio_i = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // device model state
    int          mon_cnt = 0;
    logic [63:0] mon_mdo = '0;
    logic [63:0] mon_oe = '0;
    logic [15:0] phy_reply = '0;
    time         last_rise = 0;
    time         rise_gap = 0;

    always #5 clk = ~clk;

    mdio_mgmt_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .mdc_o     (mdc_o),
        .mdio_o    (mdio_o),
        .mdio_oe_o (mdio_oe_o),
        .mdio_i    (mdio_i)
    );

    always @(posedge mdc_o) begin
        mon_mdo = {mon_mdo[62:0], mdio_o};
        mon_oe  = {mon_oe[62:0], mdio_oe_o};
        mon_cnt = mon_cnt + 1;
        if (last_rise != 0) rise_gap = $time - last_rise;
        last_rise = $time;
    end

    always @(negedge mdc_o) begin
        if (mon_cnt >= 48 && mon_cnt < 64) mdio_i = phy_reply[63 - mon_cnt];
        else mdio_i = 1'b1;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic mon_clear();
        mon_cnt = 0; mon_mdo = '0; mon_oe = '0; last_rise = 0; rise_gap = 0;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 20000; i++) begin
            bus_read(A_IND, v);
            if (v[0] == 1'b0) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        bus_read(A_IND, v); chk(v == 32'h0, "R1 indicator", v, 0);
        bus_read(A_CFG, v); chk(v == 32'h7, "R1 cfg code", v, 7);
        chk(mdc_o == 1'b0 && mdio_oe_o == 1'b0, "R1 pins low", {mdc_o, mdio_oe_o}, 0);
    endtask

    task automatic t_addr_fields();
        logic [31:0] v;
        bus_write(A_ADR, 32'hFFFF_FFFF);
        bus_read(A_ADR, v); chk(v == 32'h0000_1F1F, "R10 addr mask", v, 32'h1F1F);
    endtask

    task automatic t_write_frame();
        logic [31:0] v;
        logic [63:0] exp;
        mon_clear();
        bus_write(A_ADR, 32'h0000_130A);
        bus_write(A_WD, 32'h0000_A5C3);
        bus_read(A_IND, v); chk(v == 32'h1, "R6 busy on write", v, 1);
        wait_idle();
        repeat (4) @(posedge clk);
        exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h13, 5'h0A, 2'b10, 16'hA5C3};
        chk(mon_cnt == 64, "R4 bit count", 64'(mon_cnt), 64);
        chk(mon_mdo == exp, "R4 write frame", mon_mdo, exp);
        chk(mon_oe == '1, "R4 oe all bits", mon_oe, '1);
        chk(rise_gap == 160, "R2 period code 7", 64'(rise_gap), 160);
        chk(mdc_o == 1'b0, "R2 idle low", 64'(mdc_o), 0);
        bus_read(A_IND, v); chk(v == 32'h0, "R6 busy cleared", v, 0);
    endtask

    task automatic t_read_frame();
        logic [31:0] v;
        logic [45:0] exp_hdr;
        mon_clear();
        phy_reply = 16'h3C5A;
        bus_write(A_CMD, 32'h0);
        bus_write(A_ADR, 32'h0000_0102);
        bus_write(A_CMD, 32'h1);
        bus_read(A_IND, v); chk(v == 32'h5, "R6 busy+invalid on read", v, 5);
        wait_idle();
        exp_hdr = {32'hFFFF_FFFF, 2'b01, 2'b10, 5'h01, 5'h02};
        chk(mon_mdo[63:18] == exp_hdr, "R5 read header", 64'(mon_mdo[63:18]), 64'(exp_hdr));
        chk(mon_oe == {46'h3FFF_FFFF_FFFF, 18'h0}, "R5 oe released", mon_oe,
            {46'h3FFF_FFFF_FFFF, 18'h0});
        bus_read(A_RES, v); chk(v == 32'h3C5A, "R5 result", v, 32'h3C5A);
        bus_read(A_IND, v); chk(v == 32'h0, "R6 invalid cleared", v, 0);
    endtask

    task automatic t_cmd_edge();
        logic [31:0] v;
        mon_clear();
        bus_write(A_CMD, 32'h1);
        repeat (40) @(posedge clk);
        bus_read(A_IND, v); chk(v == 32'h0, "R8 no restart while 1", v, 0);
        chk(mon_cnt == 0, "R8 no clock", 64'(mon_cnt), 0);
        phy_reply = 16'h8001;
        bus_write(A_CMD, 32'h0);
        bus_write(A_CMD, 32'h1);
        bus_read(A_IND, v); chk(v[0] == 1'b1, "R8 start on 0-to-1", v, 1);
        wait_idle();
        bus_read(A_RES, v); chk(v == 32'h8001, "R5 result edges", v, 32'h8001);
        bus_write(A_CMD, 32'h0);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        logic [63:0] exp;
        mon_clear();
        bus_write(A_ADR, 32'h0000_0304);
        bus_write(A_WD, 32'h0000_1234);
        repeat (30) @(posedge clk);
        bus_write(A_ADR, 32'h0000_1F1F);
        bus_write(A_WD, 32'h0000_FFFF);
        bus_write(A_CMD, 32'h1);
        wait_idle();
        repeat (60) @(posedge clk);
        bus_read(A_ADR, v); chk(v == 32'h0304, "R7 addr kept", v, 32'h0304);
        bus_read(A_CMD, v); chk(v == 32'h0, "R7 cmd kept", v, 0);
        bus_read(A_WD, v);  chk(v == 32'h1234, "R7 wdata kept", v, 32'h1234);
        exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h03, 5'h04, 2'b10, 16'h1234};
        chk(mon_cnt == 64, "R7 single frame", 64'(mon_cnt), 64);
        chk(mon_mdo == exp, "R7 frame unchanged", mon_mdo, exp);
    endtask

    task automatic t_divider();
        logic [31:0] v;
        bus_write(A_CFG, 32'h0);
        bus_read(A_CFG, v); chk(v == 32'h2, "R3 clamp low", v, 2);
        bus_write(A_CFG, 32'hF);
        bus_read(A_CFG, v); chk(v == 32'h9, "R3 clamp high", v, 9);
        bus_write(A_CFG, 32'h8000_0002);
        bus_write(A_CFG, 32'h2);
        bus_read(A_CFG, v); chk(v == 32'h2, "R3 code 2", v, 2);
        mon_clear();
        bus_write(A_WD, 32'h0000_0F0F);
        wait_idle();
        chk(rise_gap == 60, "R2 period code 2", 64'(rise_gap), 60);
        chk(mon_cnt == 64, "R2 bits code 2", 64'(mon_cnt), 64);
        bus_write(A_CFG, 32'h7);
    endtask

    task automatic t_abort();
        logic [31:0] v;
        int snap;
        mon_clear();
        bus_write(A_WD, 32'h0000_5555);
        repeat (100) @(posedge clk);
        bus_write(A_CFG, 32'h8000_0007);
        bus_read(A_IND, v); chk(v == 32'h0, "R9 busy cleared", v, 0);
        chk(mdc_o == 1'b0 && mdio_oe_o == 1'b0, "R9 pins low", {mdc_o, mdio_oe_o}, 0);
        bus_read(A_CFG, v); chk(v == 32'h7, "R9 bit31 reads 0", v, 7);
        snap = mon_cnt;
        repeat (60) @(posedge clk);
        chk(mon_cnt == snap && snap < 64, "R9 frame stopped", 64'(mon_cnt), 64'(snap));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_addr_fields();
        t_write_frame();
        t_read_frame();
        t_cmd_edge();
        t_busy_ignore();
        t_divider();
        t_abort();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule